// File: doc/BRIEF.md
# Flash Read-Configuration Command Interface

This block is the command-decode state machine of a flash memory device model. It watches a plain asynchronous write bus with chip enable, write enable, address-valid, a 16-bit data bus and a word address bus. It recognises a small command set and holds the 16-bit read configuration register that steers the device's read path. The read path also receives the current read mode, which is either array or identifier.

Loading the register takes two write cycles. The first is a setup command and the second is a confirm. The configuration value does not travel on the data bus. It is taken from the low sixteen address bits, and the same value must be presented in both cycles. Each write cycle is captured at the first rising edge of any of its three strobes. After a load, or after an abandoned load, the block goes back to array mode. In identifier mode a read at word offset 05h returns the register. There is no programming-voltage input, so no load can depend on that voltage.

The bus strobes are sampled on the block clock. The strobes, address and data are assumed to be already synchronous to it.

Top module: `flash_cfg_cmd_if`

## Requirements
- R1: After reset the register holds 16'hBFC7 and the read mode is array (`rd_ident` = 0). In 16'hBFC7, bit 15 = 1 (asynchronous reads), bits 13:11 = 111 (latency), bits 10, 9, 8, 7 and 6 = 1, and bits 3:0 = 0111.
- R2: A write cycle is open while chip enable and write enable are both low. Its command word (the full 16-bit data bus) and its value (address bits 15:0) are taken at the first rising edge of address-valid, chip enable or write enable. Bus changes after that edge, and later strobe rises in the same cycle, have no effect.
- R3: Each write cycle produces exactly one capture, even when address-valid and write enable rise in the same clock.
- R4: Writing 0060h and then 0003h, with the same A[15:0] in both cycles, stores that value. The read mode is array afterwards.
- R5: If the write after a 0060h setup carries any command other than 0003h, or an A[15:0] different from the setup cycle, the register keeps its value and the read mode becomes array.
- R6: Reserved bits 14, 5 and 4 of the register always read 0, whatever was written.
- R7: Command 0090h selects identifier mode (`rd_ident` = 1). Command 00FFh selects array mode. Any other command outside a pending setup changes neither the mode nor the register.
- R8: In identifier mode, `id_rdata` equals the register while `bus_addr` = 05h. For every other address, and in array mode, `id_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_adv_n | input | 1 | Address valid, active low |
| bus_addr | input | 23 | Word address; bits 15:0 carry the configuration value on writes |
| bus_data | input | 16 | Write data; carries the command code |
| rd_ident | output | 1 | Read mode to the read path: 1 identifier, 0 array |
| cfg_value | output | 16 | Current read configuration register |
| id_rdata | output | 16 | Identifier-space read data |

## Verification
Two capture sources can land on the same clock: an address-valid rise and a write-enable rise. If both were honoured, a setup write would count twice, and the second capture would act as a malformed confirm that abandons the load. The bench raises both strobes on one edge for a setup write and follows it with a normal confirm. It judges the result by whether the new value is stored. It also moves the address after an early address-valid rise, and confirms that the stored value is the one present at that first edge.

// File: rtl/flash_cfg_pkg.sv
package flash_cfg_pkg;
   localparam int CFG_W = 16;
   localparam int CMD_W = 8;

   localparam logic [CMD_W-1:0] CMD_CFG_SETUP   = 8'h60;
   localparam logic [CMD_W-1:0] CMD_CFG_CONFIRM = 8'h03;
   localparam logic [CMD_W-1:0] CMD_READ_ID     = 8'h90;
   localparam logic [CMD_W-1:0] CMD_READ_ARRAY  = 8'hFF;

   localparam logic [CFG_W-1:0] CFG_RESET_VAL = 16'hBFC7;
   localparam logic [CFG_W-1:0] CFG_RSV_MASK  = 16'h4030;

   typedef enum logic [1:0] {
      ST_ARRAY = 2'd0,
      ST_IDENT = 2'd1,
      ST_PEND  = 2'd2
   } cmd_state_t;
endpackage

// File: rtl/fcc_strobe_capture.sv
module fcc_strobe_capture
   import flash_cfg_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              adv_n,
   input  logic [CFG_W-1:0]  addr_lo,
   input  logic [DATA_W-1:0] data,
   output logic              evt_valid,
   output logic [CFG_W-1:0]  evt_val,
   output logic [DATA_W-1:0] evt_cmd
);
   logic              ce_q, we_q, adv_q, done_q;
   logic [CFG_W-1:0]  addr_q;
   logic [DATA_W-1:0] data_q;
   logic              cyc_open, rise_any, fire;

   assign cyc_open = !ce_q && !we_q && !done_q;
   assign rise_any = (!ce_q && ce_n) || (!we_q && we_n) || (!adv_q && adv_n);
   assign fire     = cyc_open && rise_any;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ce_q      <= 1'b1;
         we_q      <= 1'b1;
         adv_q     <= 1'b1;
         done_q    <= 1'b0;
         addr_q    <= '0;
         data_q    <= '0;
         evt_valid <= 1'b0;
         evt_val   <= '0;
         evt_cmd   <= '0;
      end else begin
         ce_q      <= ce_n;
         we_q      <= we_n;
         adv_q     <= adv_n;
         addr_q    <= addr_lo;
         data_q    <= data;
         evt_valid <= fire;
         if (fire) begin
            evt_val <= addr_q;
            evt_cmd <= data_q;
         end
         if (fire)
            done_q <= 1'b1;
         else if (ce_n || we_n)
            done_q <= 1'b0;
      end
   end

   // R3
   single_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |=> !evt_valid);
endmodule

// File: rtl/fcc_cmd_fsm.sv
module fcc_cmd_fsm
   import flash_cfg_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter bit REQUIRE_MATCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid,
   input  logic [CFG_W-1:0]  evt_val,
   input  logic [DATA_W-1:0] evt_cmd,
   output logic              ident_mode,
   output logic              load_en,
   output logic [CFG_W-1:0]  load_val
);
   localparam logic [DATA_W-1:0] W_SETUP   = DATA_W'(CMD_CFG_SETUP);
   localparam logic [DATA_W-1:0] W_CONFIRM = DATA_W'(CMD_CFG_CONFIRM);
   localparam logic [DATA_W-1:0] W_READ_ID = DATA_W'(CMD_READ_ID);
   localparam logic [DATA_W-1:0] W_READ_AR = DATA_W'(CMD_READ_ARRAY);

   cmd_state_t       state_q;
   logic [CFG_W-1:0] pend_val_q;
   logic             val_ok;

   generate
      if (REQUIRE_MATCH) begin : g_match
         assign val_ok = (evt_val == pend_val_q);
      end else begin : g_nomatch
         assign val_ok = 1'b1;
      end
   endgenerate

   assign load_en    = evt_valid && (state_q == ST_PEND) && (evt_cmd == W_CONFIRM) && val_ok;
   assign load_val   = evt_val;
   assign ident_mode = (state_q == ST_IDENT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_ARRAY;
         pend_val_q <= '0;
      end else if (evt_valid) begin
         if (state_q == ST_PEND) begin
            state_q <= ST_ARRAY;
         end else if (evt_cmd == W_SETUP) begin
            state_q    <= ST_PEND;
            pend_val_q <= evt_val;
         end else if (evt_cmd == W_READ_ID) begin
            state_q <= ST_IDENT;
         end else if (evt_cmd == W_READ_AR) begin
            state_q <= ST_ARRAY;
         end
      end
   end

   // R4
   pend_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PEND && evt_valid) |=> (state_q == ST_ARRAY));
endmodule

// File: rtl/fcc_cfg_reg.sv
module fcc_cfg_reg
   import flash_cfg_pkg::*;
#(
   parameter logic [CFG_W-1:0] RESET_VAL = CFG_RESET_VAL,
   parameter logic [CFG_W-1:0] RSV_MASK  = CFG_RSV_MASK
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic [CFG_W-1:0] load_val,
   output logic [CFG_W-1:0] cfg
);
   logic [CFG_W-1:0] cfg_q, wr_val;

   generate
      if (RSV_MASK == '0) begin : g_plain
         assign wr_val = load_val;
      end else begin : g_masked
         assign wr_val = load_val & ~RSV_MASK;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         cfg_q <= RESET_VAL;
      else if (load_en)
         cfg_q <= wr_val;
   end

   assign cfg = cfg_q;
endmodule

// File: rtl/flash_cfg_cmd_if.sv
module flash_cfg_cmd_if
   import flash_cfg_pkg::*;
#(
   parameter int               ADDR_W        = 23,
   parameter int               DATA_W        = 16,
   parameter int               ID_OFFSET     = 5,
   parameter bit               REQUIRE_MATCH = 1'b1,
   parameter logic [CFG_W-1:0] RESET_VAL     = CFG_RESET_VAL,
   parameter logic [CFG_W-1:0] RSV_MASK      = CFG_RSV_MASK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_ce_n,
   input  logic              bus_we_n,
   input  logic              bus_adv_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   output logic              rd_ident,
   output logic [CFG_W-1:0]  cfg_value,
   output logic [CFG_W-1:0]  id_rdata
);
   localparam logic [ADDR_W-1:0] ID_ADDR = ADDR_W'(ID_OFFSET);

   generate
      if (ADDR_W < CFG_W) begin : g_bad_addr
         $error("ADDR_W must cover the configuration value");
      end
      if (DATA_W < CMD_W) begin : g_bad_data
         $error("DATA_W must hold a command byte");
      end
      if ((RESET_VAL & RSV_MASK) != '0) begin : g_bad_default
         $error("reset value sets reserved bits");
      end
   endgenerate

   logic              evt_valid, load_en, ident_mode;
   logic [CFG_W-1:0]  evt_val, load_val, cfg;
   logic [DATA_W-1:0] evt_cmd;

   fcc_strobe_capture #(.DATA_W(DATA_W)) u_cap (
      .clk(clk), .rst_n(rst_n),
      .ce_n(bus_ce_n), .we_n(bus_we_n), .adv_n(bus_adv_n),
      .addr_lo(bus_addr[CFG_W-1:0]), .data(bus_data),
      .evt_valid(evt_valid), .evt_val(evt_val), .evt_cmd(evt_cmd)
   );

   fcc_cmd_fsm #(.DATA_W(DATA_W), .REQUIRE_MATCH(REQUIRE_MATCH)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .evt_valid(evt_valid), .evt_val(evt_val), .evt_cmd(evt_cmd),
      .ident_mode(ident_mode), .load_en(load_en), .load_val(load_val)
   );

   fcc_cfg_reg #(.RESET_VAL(RESET_VAL), .RSV_MASK(RSV_MASK)) u_reg (
      .clk(clk), .rst_n(rst_n),
      .load_en(load_en), .load_val(load_val), .cfg(cfg)
   );

   assign rd_ident  = ident_mode;
   assign cfg_value = cfg;
   assign id_rdata  = (ident_mode && bus_addr == ID_ADDR) ? cfg : '0;

   // R5
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_valid |=> $stable(cfg_value));
   // R6
   rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_value & RSV_MASK) == '0);
endmodule

// File: tb/flash_cfg_cmd_if_tb.sv
module flash_cfg_cmd_if_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, we_n = 1'b1, adv_n = 1'b1;
   logic [22:0] addr = '0;
   logic [15:0] data = '0;
   logic        rd_ident;
   logic [15:0] cfg_value, id_rdata;

   int checks = 0;
   int errors = 0;
   logic [15:0] m_cfg;
   logic        m_ident;

   always #2.5 clk = ~clk;

   flash_cfg_cmd_if u_dut (
      .clk(clk), .rst_n(rst_n),
      .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_adv_n(adv_n),
      .bus_addr(addr), .bus_data(data),
      .rd_ident(rd_ident), .cfg_value(cfg_value), .id_rdata(id_rdata)
   );

   function automatic logic [15:0] stored(input logic [15:0] v);
      return v & ~16'h4030;
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // style 0: we first, 1: adv first then bus changes, 2: ce first, 3: adv and we together
   task automatic bus_write(input logic [15:0] cmd, input logic [15:0] val, input int style);
      @(negedge clk);
      addr = {7'h0, val}; data = cmd; ce_n = 0; we_n = 0; adv_n = 0;
      @(negedge clk);
      case (style)
         1: begin
            adv_n = 1;
            @(negedge clk); addr = {7'h0, ~val}; data = ~cmd;
            @(negedge clk); we_n = 1;
            @(negedge clk); ce_n = 1;
         end
         2: begin
            ce_n = 1;
            @(negedge clk); we_n = 1; adv_n = 1;
         end
         3: begin
            adv_n = 1; we_n = 1;
            @(negedge clk); ce_n = 1;
         end
         default: begin
            we_n = 1;
            @(negedge clk); ce_n = 1; adv_n = 1;
         end
      endcase
      @(negedge clk); @(negedge clk); @(negedge clk);
   endtask

   task automatic bus_read(input logic [22:0] a, output logic [15:0] d);
      @(negedge clk);
      addr = a; ce_n = 0; we_n = 1;
      @(negedge clk);
      d = id_rdata;
      ce_n = 1;
   endtask

   task automatic verify(input string tag);
      logic [15:0] d;
      check({tag, " R6 cfg"}, cfg_value, m_cfg);
      check({tag, " R7 mode"}, {15'h0, rd_ident}, {15'h0, m_ident});
      bus_read(23'h5, d);
      check({tag, " R8 off05"}, d, m_ident ? m_cfg : 16'h0);
      bus_read(23'h6, d);
      check({tag, " R8 off06"}, d, 16'h0);
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] v, d;
      int r;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      m_cfg = 16'hBFC7; m_ident = 0;
      // R1 reset defaults
      check("R1 default", cfg_value, 16'hBFC7);
      check("R1 mode", {15'h0, rd_ident}, 16'h0);
      bus_write(16'h0090, 16'h0, 0); m_ident = 1;
      bus_read(23'h5, d);
      check("R1 R8 default readback", d, 16'hBFC7);
      // R4 load with all bits set, R6 reserved cleared
      bus_write(16'h0060, 16'hFFFF, 0);
      check("R4 pending mode array", {15'h0, rd_ident}, 16'h0);
      bus_write(16'h0003, 16'hFFFF, 0);
      m_cfg = 16'hBFCF; m_ident = 0;
      verify("R4 R6 all ones");
      // R2 adv first, bus moves afterwards
      bus_write(16'h0060, 16'h1234, 1);
      bus_write(16'h0003, 16'h1234, 1);
      m_cfg = stored(16'h1234);
      verify("R2 adv first");
      // R2 ce first
      bus_write(16'h0060, 16'h8A0F, 2);
      bus_write(16'h0003, 16'h8A0F, 2);
      m_cfg = stored(16'h8A0F);
      verify("R2 ce first");
      // R3 adv and we rise together: one capture only
      bus_write(16'h0060, 16'h2D41, 3);
      bus_write(16'h0003, 16'h2D41, 0);
      m_cfg = stored(16'h2D41);
      verify("R3 same edge");
      // R5 bad confirm from ident mode
      bus_write(16'h0090, 16'h0, 0);
      bus_write(16'h0060, 16'h0F0F, 0);
      bus_write(16'h00D0, 16'h0F0F, 0);
      m_ident = 0;
      verify("R5 bad confirm");
      // R5 value mismatch
      bus_write(16'h0060, 16'h5555, 0);
      bus_write(16'h0003, 16'h5554, 0);
      verify("R5 mismatch");
      // R7 junk ignored in ident, upper data byte set is unrecognised
      bus_write(16'h0090, 16'h0, 0); m_ident = 1;
      bus_write(16'h0003, 16'h7777, 0);
      bus_write(16'h01FF, 16'h0, 0);
      verify("R7 junk ignored");
      bus_write(16'h00FF, 16'h0, 0); m_ident = 0;
      verify("R7 read array");

      for (int i = 0; i < 250; i++) begin
         r = int'($urandom % 6);
         v = 16'($urandom);
         case (r)
            0: begin
               bus_write(16'h0060, v, int'($urandom % 4));
               bus_write(16'h0003, v, int'($urandom % 4));
               m_cfg = stored(v); m_ident = 0;
               verify("R4 rand load");
            end
            1: begin
               d = 16'($urandom % 256);
               if (d == 16'h0003) d = 16'h0004;
               bus_write(16'h0060, v, int'($urandom % 4));
               bus_write(d, v, int'($urandom % 4));
               m_ident = 0;
               verify("R5 rand bad code");
            end
            2: begin
               bus_write(16'h0060, v, 0);
               bus_write(16'h0003, v ^ (16'h1 << ($urandom % 16)), 0);
               m_ident = 0;
               verify("R5 rand mismatch");
            end
            3: begin
               bus_write(16'h0090, v, int'($urandom % 4));
               m_ident = 1;
               verify("R7 rand ident");
            end
            4: begin
               bus_write(16'h00FF, v, int'($urandom % 4));
               m_ident = 0;
               verify("R7 rand array");
            end
            default: begin
               d = 16'($urandom % 256);
               if (d == 16'h0060 || d == 16'h0090 || d == 16'h00FF) d = 16'h0011;
               bus_write(d, v, int'($urandom % 4));
               verify("R7 rand junk");
            end
         endcase
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule